// File: doc/BRIEF.md
# ADC Result Accumulator and Filter

This block post-processes the stream of ADC conversion results. Each time a conversion finishes, the converter presents a result word with a one-cycle valid strobe. The block folds that word into a 16-bit accumulator. A single right-shift setting turns the accumulator into a scaled output. The same register and adder serve four operating modes. Plain accumulation keeps summing for as long as samples arrive. Average mode starts a fresh sum once the programmed count is reached. Burst-average mode stops taking samples at that count until software clears it. Low-pass mode is a first-order recursive filter, and its shift setting sets the cutoff: values 1 to 6 move the -3 dB point down from about 0.72 rad/sample to about 0.016 rad/sample.

A sample counter tracks how many results have gone into the current sum. Its comparison with the repeat setting gives a completion level and a one-cycle completion pulse. A sticky flag records that an addition went past the 16-bit range. Software clears the sum, the counter and that flag with a clear request. The clear is self-completing and keeps a busy output high for five clock cycles. Results that arrive while the busy output is high are dropped.

Top module: `adc_acc_filter`

## Requirements
- R1: After reset, accOut, sampleCount, overflowFlag, clearBusy and donePulse are all 0.
- R2: With modeSel = 0 (accumulate), each accepted sample adds sampleData to accOut and increments sampleCount, including past the repeat setting.
- R3: When an addition produces a value above 65535, overflowFlag goes to 1 and stays 1 until a clear. accOut keeps the low 16 bits of the sum.
- R4: resultOut always equals accOut shifted right by shiftSel bits.
- R5: With modeSel = 1 (average), a sample accepted while sampleCount equals repeatCount restarts the sum: accOut becomes sampleData and sampleCount becomes 1.
- R6: With modeSel = 2 (burst average), a sample arriving while sampleCount equals repeatCount is ignored, and accOut and sampleCount hold until a clear.
- R7: With modeSel = 3 (low-pass), each accepted sample sets accOut to accOut + sampleData - (accOut >> shiftSel).
- R8: doneFlag is 1 whenever sampleCount equals repeatCount. donePulse is 1 for the single cycle after the clock edge at which an accepted sample brings sampleCount to repeatCount.
- R9: A clearReq pulse while clearBusy is 0 zeroes accOut, sampleCount and overflowFlag at the next edge. It then holds clearBusy at 1 for exactly 5 cycles.
- R10: Samples presented while clearBusy is 1, or in the same cycle as an accepted clearReq, change neither accOut nor sampleCount.
- R11: sampleCount saturates at its maximum value (255) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe per conversion result |
| sampleData | input | 12 | Conversion result |
| clearReq | input | 1 | Software clear request pulse |
| modeSel | input | 2 | 0 accumulate, 1 average, 2 burst average, 3 low-pass |
| repeatCount | input | 8 | Number of samples that completes a sum |
| shiftSel | input | 3 | Right-shift applied to the accumulator |
| accOut | output | 16 | Raw accumulator |
| resultOut | output | 16 | Accumulator shifted right by shiftSel |
| sampleCount | output | 8 | Samples folded into the current sum |
| doneFlag | output | 1 | sampleCount equals repeatCount |
| donePulse | output | 1 | One-cycle completion pulse |
| overflowFlag | output | 1 | Sticky accumulator overflow |
| clearBusy | output | 1 | Clear in progress |

## Verification
The hardest case to reach is the five-cycle clear window with a sample pending. The bench raises clearReq and then holds sampleValid high through the entire busy period. It counts the busy cycles at each falling edge and confirms that the sum and the count are still zero in the first cycle after busy drops. Overflow needs a long run of full-scale samples. The bench sends sixteen samples of 4095 to stop just short of the limit, then one more to cross it. Counter saturation is reached by holding sampleValid high for 257 cycles.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;

  typedef enum logic [1:0] {
    MODE_ACCUM   = 2'd0,
    MODE_AVG     = 2'd1,
    MODE_BURST   = 2'd2,
    MODE_LOWPASS = 2'd3
  } accMode_e;

  // Strobes from the control module to the datapath, valid for one cycle
  typedef struct packed {
    logic addSample;  // fold sample into the running sum
    logic restart;    // start a fresh sum with this sample
    logic clearAll;   // zero sum and overflow flag
    logic lowPass;    // subtract the leak term during addSample
  } accStrobe_t;

endpackage

// File: rtl/adc_acc_shifter.sv
module adc_acc_shifter #(
  parameter int WIDTH   = 16,
  parameter int SHIFT_W = 3
) (
  input  logic [WIDTH-1:0]   dataIn,
  input  logic [SHIFT_W-1:0] shiftSel,
  output logic [WIDTH-1:0]   dataOut
);

  // Logarithmic shifter: stage g shifts by 2**g when its select bit is set
  logic [WIDTH-1:0] stageVal [SHIFT_W+1];

  assign stageVal[0] = dataIn;

  for (genvar g = 0; g < SHIFT_W; g++) begin : g_stage
    assign stageVal[g+1] = shiftSel[g] ? (stageVal[g] >> (1 << g)) : stageVal[g];
  end

  assign dataOut = stageVal[SHIFT_W];

endmodule

// File: rtl/adc_acc_datapath.sv
module adc_acc_datapath
  import adc_acc_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int ACC_W   = 16,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  accStrobe_t         strb,
  input  logic [DATA_W-1:0]  sampleData,
  input  logic [SHIFT_W-1:0] shiftSel,
  output logic [ACC_W-1:0]   accOut,
  output logic [ACC_W-1:0]   resultOut,
  output logic               overflowFlag
);

  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] accReg;
  logic             ovfReg;
  logic [ACC_W-1:0] leakRaw;
  logic [SUM_W-1:0] extAcc;
  logic [SUM_W-1:0] extSample;
  logic [SUM_W-1:0] leakTerm;
  logic [SUM_W-1:0] nextSum;

  // The leak term uses the same shifter as the output path
  adc_acc_shifter #(.WIDTH(ACC_W), .SHIFT_W(SHIFT_W)) leakShift_i (
    .dataIn  (accReg),
    .shiftSel(shiftSel),
    .dataOut (leakRaw)
  );

  always_comb begin
    extAcc    = {1'b0, accReg};
    extSample = SUM_W'(sampleData);
    leakTerm  = strb.lowPass ? {1'b0, leakRaw} : '0;
    // leakTerm never exceeds extAcc, so the sum cannot go negative
    nextSum   = extAcc - leakTerm + extSample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accReg <= '0;
      ovfReg <= 1'b0;
    end else if (strb.clearAll) begin
      accReg <= '0;
      ovfReg <= 1'b0;
    end else if (strb.restart) begin
      accReg <= ACC_W'(sampleData);
    end else if (strb.addSample) begin
      accReg <= nextSum[ACC_W-1:0];
      if (nextSum[SUM_W-1]) ovfReg <= 1'b1;
    end
  end

  assign accOut       = accReg;
  assign resultOut    = leakRaw;
  assign overflowFlag = ovfReg;

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfReg && !strb.clearAll) |=> ovfReg);

  assert_clear_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAll |=> (accReg == '0 && !ovfReg));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.addSample && !strb.restart && !strb.clearAll) |=> $stable(accReg));

endmodule

// File: rtl/adc_acc_ctrl.sv
module adc_acc_ctrl
  import adc_acc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int CLR_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleValid,
  input  logic             clearReq,
  input  logic [1:0]       modeSel,
  input  logic [CNT_W-1:0] repeatCount,
  output accStrobe_t       strb,
  output logic [CNT_W-1:0] sampleCount,
  output logic             doneFlag,
  output logic             donePulse,
  output logic             clearBusy
);

  localparam int BUSY_W = $clog2(CLR_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [BUSY_W-1:0] BUSY_END = BUSY_W'(CLR_CYCLES - 1);

  accMode_e          curMode;
  logic [CNT_W-1:0]  cntReg;
  logic [CNT_W-1:0]  cntNext;
  logic [BUSY_W-1:0] busyCnt;
  logic              busyReg;
  logic              pulseReg;
  logic              atRepeat;
  logic              accept;
  logic              holdOff;
  logic              clearStart;

  always_comb begin
    curMode    = accMode_e'(modeSel);
    atRepeat   = (cntReg == repeatCount);
    clearStart = clearReq && !busyReg;
    accept     = sampleValid && !busyReg && !clearReq;
    holdOff    = (curMode == MODE_BURST) && atRepeat;

    strb           = '0;
    strb.clearAll  = clearStart;
    strb.restart   = accept && (curMode == MODE_AVG) && atRepeat;
    strb.addSample = accept && !holdOff && !strb.restart;
    strb.lowPass   = (curMode == MODE_LOWPASS);

    if (strb.restart)
      cntNext = CNT_W'(1);
    else if (strb.addSample && cntReg != CNT_MAX)
      cntNext = cntReg + 1'b1;
    else
      cntNext = cntReg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntReg   <= '0;
      busyReg  <= 1'b0;
      busyCnt  <= '0;
      pulseReg <= 1'b0;
    end else begin
      pulseReg <= (strb.addSample || strb.restart) && (cntNext == repeatCount);
      if (clearStart) begin
        cntReg  <= '0;
        busyReg <= 1'b1;
        busyCnt <= '0;
      end else begin
        cntReg <= cntNext;
        if (busyReg) begin
          if (busyCnt == BUSY_END) busyReg <= 1'b0;
          else                     busyCnt <= busyCnt + 1'b1;
        end
      end
    end
  end

  assign sampleCount = cntReg;
  assign doneFlag    = atRepeat;
  assign donePulse   = pulseReg;
  assign clearBusy   = busyReg;

  assert_clear_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clearReq && !clearBusy) |=> (clearBusy && sampleCount == '0));

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clearBusy |=> $stable(sampleCount));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> (sampleCount == $past(repeatCount)));

  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'd2 && sampleCount == repeatCount && !clearReq) |=> $stable(sampleCount));

  assert_cnt_nowrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleCount == CNT_MAX && !clearReq && !(sampleValid && modeSel == 2'd1 && doneFlag))
      |=> (sampleCount == CNT_MAX));

endmodule

// File: rtl/adc_acc_filter.sv
module adc_acc_filter
  import adc_acc_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int ACC_W      = 16,
  parameter int CNT_W      = 8,
  parameter int SHIFT_W    = 3,
  parameter int CLR_CYCLES = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleValid,
  input  logic [DATA_W-1:0]  sampleData,
  input  logic               clearReq,
  input  logic [1:0]         modeSel,
  input  logic [CNT_W-1:0]   repeatCount,
  input  logic [SHIFT_W-1:0] shiftSel,
  output logic [ACC_W-1:0]   accOut,
  output logic [ACC_W-1:0]   resultOut,
  output logic [CNT_W-1:0]   sampleCount,
  output logic               doneFlag,
  output logic               donePulse,
  output logic               overflowFlag,
  output logic               clearBusy
);

  accStrobe_t strb;

  adc_acc_ctrl #(.CNT_W(CNT_W), .CLR_CYCLES(CLR_CYCLES)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .clearReq   (clearReq),
    .modeSel    (modeSel),
    .repeatCount(repeatCount),
    .strb       (strb),
    .sampleCount(sampleCount),
    .doneFlag   (doneFlag),
    .donePulse  (donePulse),
    .clearBusy  (clearBusy)
  );

  adc_acc_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) dpath_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .sampleData  (sampleData),
    .shiftSel    (shiftSel),
    .accOut      (accOut),
    .resultOut   (resultOut),
    .overflowFlag(overflowFlag)
  );

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (accOut == '0 && sampleCount == '0 && !overflowFlag && !clearBusy && !donePulse));

endmodule

// File: tb/adc_acc_filter_tb_top.sv
module adc_acc_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        clearReq = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [7:0]  repeatCount = 8'd4;
  logic [2:0]  shiftSel = 3'd0;
  logic [15:0] accOut;
  logic [15:0] resultOut;
  logic [7:0]  sampleCount;
  logic        doneFlag;
  logic        donePulse;
  logic        overflowFlag;
  logic        clearBusy;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  adc_acc_filter dut_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
    .clearReq(clearReq), .modeSel(modeSel), .repeatCount(repeatCount), .shiftSel(shiftSel),
    .accOut(accOut), .resultOut(resultOut), .sampleCount(sampleCount), .doneFlag(doneFlag),
    .donePulse(donePulse), .overflowFlag(overflowFlag), .clearBusy(clearBusy)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one sample for one edge; returns at the following falling edge
  task automatic sendSample(input logic [11:0] val);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = val;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    while (clearBusy) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "accOut", accOut, 0);
    check("R1", "sampleCount", sampleCount, 0);
    check("R1", "overflowFlag", overflowFlag, 0);
    check("R1", "clearBusy", clearBusy, 0);
    check("R1", "donePulse", donePulse, 0);
  endtask

  task automatic t_accumulate();
    modeSel = 2'd0; repeatCount = 8'd4; shiftSel = 3'd2;
    sendSample(12'd100);
    sendSample(12'd200);
    sendSample(12'd300);
    check("R8", "doneFlag before count", doneFlag, 0);
    sendSample(12'd400);
    check("R2", "accOut after 4", accOut, 1000);
    check("R2", "count after 4", sampleCount, 4);
    check("R4", "resultOut shift 2", resultOut, 250);
    check("R8", "donePulse", donePulse, 1);
    check("R8", "doneFlag", doneFlag, 1);
    @(negedge clk);
    check("R8", "donePulse one cycle", donePulse, 0);
    sendSample(12'd50);
    check("R2", "accOut past repeat", accOut, 1050);
    check("R2", "count past repeat", sampleCount, 5);
    check("R8", "doneFlag past repeat", doneFlag, 0);
    shiftSel = 3'd5;
    #1;
    check("R4", "resultOut shift 5", resultOut, 1050 >> 5);
    shiftSel = 3'd0;
    #1;
    check("R4", "resultOut shift 0", resultOut, 1050);
  endtask

  task automatic t_clear();
    int busyCycles = 0;
    @(negedge clk);
    clearReq = 1'b1;
    sampleValid = 1'b1; sampleData = 12'd33;  // same cycle as the clear: dropped
    @(negedge clk);
    clearReq = 1'b0;
    sampleData = 12'd77;                      // held through the busy window
    check("R9", "accOut cleared", accOut, 0);
    check("R9", "count cleared", sampleCount, 0);
    for (int i = 0; i < 8; i++) begin
      if (clearBusy) busyCycles++;
      @(negedge clk);
      if (!clearBusy) break;
    end
    sampleValid = 1'b0;
    check("R9", "busy length", busyCycles, 5);
    check("R10", "accOut after busy", accOut, 0);
    check("R10", "count after busy", sampleCount, 0);
    sendSample(12'd77);
    check("R10", "accept after busy", accOut, 77);
  endtask

  task automatic t_overflow();
    doClear();
    modeSel = 2'd0; repeatCount = 8'd100;
    for (int i = 0; i < 16; i++) sendSample(12'd4095);
    check("R3", "acc at 16 full-scale", accOut, 65520);
    check("R3", "no overflow yet", overflowFlag, 0);
    sendSample(12'd4095);
    check("R3", "acc wraps", accOut, 4079);
    check("R3", "overflow set", overflowFlag, 1);
    sendSample(12'd10);
    check("R3", "overflow sticky", overflowFlag, 1);
    check("R3", "acc after wrap", accOut, 4089);
    doClear();
    check("R9", "overflow cleared", overflowFlag, 0);
  endtask

  task automatic t_average();
    doClear();
    modeSel = 2'd1; repeatCount = 8'd3; shiftSel = 3'd0;
    sendSample(12'd10);
    sendSample(12'd20);
    sendSample(12'd30);
    check("R5", "avg sum", accOut, 60);
    check("R8", "avg donePulse", donePulse, 1);
    sendSample(12'd5);
    check("R5", "avg restart acc", accOut, 5);
    check("R5", "avg restart count", sampleCount, 1);
  endtask

  task automatic t_burst();
    doClear();
    modeSel = 2'd2; repeatCount = 8'd2;
    sendSample(12'd7);
    sendSample(12'd8);
    check("R6", "burst sum", accOut, 15);
    check("R8", "burst doneFlag", doneFlag, 1);
    sendSample(12'd9);
    check("R6", "burst hold acc", accOut, 15);
    check("R6", "burst hold count", sampleCount, 2);
    doClear();
    sendSample(12'd9);
    check("R6", "burst after clear", accOut, 9);
  endtask

  task automatic t_lowpass(input logic [2:0] sh, input logic [11:0] val, input int n);
    int model = 0;
    doClear();
    modeSel = 2'd3; repeatCount = 8'd200; shiftSel = sh;
    for (int i = 0; i < n; i++) begin
      sendSample(val);
      model = model + int'(val) - (model >> sh);
      check("R7", $sformatf("lowpass shift %0d step %0d", sh, i), accOut, model);
    end
    check("R4", "lowpass resultOut", resultOut, model >> sh);
  endtask

  task automatic t_saturate();
    doClear();
    modeSel = 2'd0; repeatCount = 8'd10;
    @(negedge clk);
    sampleValid = 1'b1; sampleData = 12'd0;
    repeat (257) @(negedge clk);
    sampleValid = 1'b0;
    check("R11", "count saturates", sampleCount, 255);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_accumulate();
    t_clear();
    t_overflow();
    t_average();
    t_burst();
    t_lowpass(3'd2, 12'd1000, 8);
    t_lowpass(3'd1, 12'd4095, 6);
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule